// File: doc/BRIEF.md
# Pulse-Swallow BCD Programmable Divider

This block divides a fast input clock by a decimal factor N. It uses a dual-modulus prescaler that divides by 10 or 11, together with a programmable counter that works in prescaler cycles. N is written as BCD, one 4-bit digit per write, most significant digit first. The final write carries a marker that says it is the units digit. The block treats N as 10·M + A, where A is the units digit and M is the value of the higher digits. Each output period has M prescaler cycles. The first A of them divide by 11 and the rest divide by 10.

The block gives two outputs, each one input clock wide. The fast pulse is taken from the counter state at the start of the final prescaler cycle, so its timing depends on how long that cycle is. The slow pulse marks the exact last clock of every period and is free of jitter. A completed, valid divisor is held in a shadow store and reaches the counters only at a period boundary. A malformed or out-of-range divisor is refused and an error flag is set.

Top module: `psd_divider`

## Requirements
- R1: The interval between consecutive `slow_pulse` assertions is exactly N input clocks, where N is the divisor in force for that period.
- R2: In each period, `mod_hi` (1 = divide by 11) is high for exactly 11·A input clocks, A being the units digit of N. It changes only at the end of a prescaler cycle.
- R3: `fast_pulse` and `slow_pulse` are each high for one clock. When the final prescaler cycle divides by 10, `fast_pulse` rises 9 clocks before `slow_pulse`.
- R4: Digits are written with `dig_valid`, most significant digit first. The write that carries `dig_last` supplies the units digit. Suppose the units digit is sampled at edge k. Any period that ends on edge k+1 keeps the old divisor. The first period that ends on edge k+2 or later is followed by periods of the new divisor.
- R5: A load is refused when any digit exceeds 9, when more than NUM_DIGITS digits are written, or when N falls outside N_MIN..N_MAX. One clock after the units digit, `load_err` goes high, and the divisor in force or pending does not change.
- R6: An accepted load clears `load_err` one clock after its units digit. `load_err` otherwise holds its value.
- R7: The reset is synchronous and active low. While it is held, `fast_pulse`, `slow_pulse` and `load_err` are low. Any pending divisor is discarded. Counting restarts with N_BOOT, and the first `slow_pulse` comes N_BOOT clocks after the last reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock that is divided |
| rst_n | input | 1 | Synchronous active-low reset |
| dig_valid | input | 1 | A BCD digit is present on `dig_data` this cycle |
| dig_data | input | 4 | BCD digit, most significant first |
| dig_last | input | 1 | Marks the units digit, which completes the divisor |
| fast_pulse | output | 1 | Early feedback pulse, one clock wide |
| slow_pulse | output | 1 | Jitter-free pulse on the last clock of each period |
| mod_hi | output | 1 | Current prescaler modulus, 1 = divide by 11 |
| load_err | output | 1 | The last completed load was refused |

## Verification
A completed divisor load can land in the same clock as a period end. In that case the end of period already takes its next divisor from the active or shadow store, while the new commit is only being written into the shadow store. The bench watches the slow pulse and then places the units digit two clocks before the next period end. This forces the commit onto that boundary edge. The bench expects one more period of the old divisor before the new one applies. It repeats the load one clock earlier and expects the new divisor to apply at once. A reference model in the bench follows the same edge rule to judge every period length and swallow count.

// File: rtl/psd_pkg.sv
// Package psd_pkg
// Shared digit type and prescaler moduli for the pulse-swallow divider.
// Assumes digits are 4-bit BCD, with valid codes 0..9.
package psd_pkg;
    typedef logic [3:0] bcd_t;
    localparam bcd_t BCD_MAX   = 4'd9;
    localparam int   PRE_SHORT = 10;
    localparam int   PRE_LONG  = 11;
endpackage

// File: rtl/psd_loader.sv
// Module psd_loader
// Takes BCD digits one per write, most significant first, and builds the
// binary value of the higher digits (M) as they arrive. The units-digit
// write validates the complete divisor and either commits {M, A} for one
// cycle or raises the error flag.
// Assumes: at most NUM_DIGITS digits per divisor; dig_last marks the units digit.
module psd_loader
    import psd_pkg::*;
#(
    parameter int NUM_DIGITS = 6,
    parameter int N_MIN      = 50000,
    parameter int N_MAX      = 220000,
    parameter int M_W        = 15
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dig_valid,
    input  bcd_t           dig_data,
    input  logic           dig_last,
    output logic           commit,
    output logic [M_W-1:0] commit_m,
    output bcd_t           commit_a,
    output logic           load_err
);
    localparam int ACC_W = $clog2(10 ** NUM_DIGITS);
    localparam int VAL_W = ACC_W + 4;
    localparam int CNT_W = $clog2(NUM_DIGITS + 1);

    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             bad_q;
    logic             commit_q;
    logic             err_q;
    logic [M_W-1:0]   cm_q;
    bcd_t             ca_q;

    logic             digit_bad;
    logic             too_many;
    logic [VAL_W-1:0] full_val;
    logic             in_range;
    logic             units_fit;
    logic             accept;

    // Decide whether the digit on the bus is usable and whether the divisor it completes is legal.
    always_comb begin
        digit_bad = (dig_data > BCD_MAX);
        too_many  = (int'(cnt_q) >= NUM_DIGITS - 1);
        full_val  = VAL_W'(acc_q) * VAL_W'(10) + VAL_W'(dig_data);
        in_range  = (full_val >= VAL_W'(N_MIN)) && (full_val <= VAL_W'(N_MAX));
        units_fit = (acc_q >= ACC_W'(dig_data));
        accept    = !bad_q && !digit_bad && in_range && units_fit;
    end

    // Accumulate the higher digits and issue a commit or an error on the units digit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            bad_q    <= 1'b0;
            commit_q <= 1'b0;
            err_q    <= 1'b0;
            cm_q     <= '0;
            ca_q     <= '0;
        end else begin
            commit_q <= 1'b0;
            if (dig_valid && dig_last) begin
                acc_q <= '0;
                cnt_q <= '0;
                bad_q <= 1'b0;
                if (accept) begin
                    commit_q <= 1'b1;
                    cm_q     <= M_W'(acc_q);
                    ca_q     <= dig_data;
                    err_q    <= 1'b0;
                end else begin
                    err_q    <= 1'b1;
                end
            end else if (dig_valid) begin
                if (!digit_bad && !too_many) begin
                    acc_q <= ACC_W'(acc_q * ACC_W'(10) + ACC_W'(dig_data));
                    cnt_q <= cnt_q + 1'b1;
                end else begin
                    bad_q <= 1'b1;
                end
            end
        end
    end

    assign commit   = commit_q;
    assign commit_m = cm_q;
    assign commit_a = ca_q;
    assign load_err = err_q;

    AST_COMMIT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> $past(dig_valid && dig_last)); // R4
    AST_REJECT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> !commit_q); // R5
    AST_COMMIT_UNITS_BCD: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> (ca_q <= BCD_MAX)); // R5
endmodule

// File: rtl/psd_prescaler.sv
// Module psd_prescaler
// Dual-modulus prescaler that divides by 10 or 11. The requested modulus
// is latched only on the last clock of a prescaler cycle, so a cycle never
// changes length partway through.
// Assumes mod_next is valid whenever ps_end is high.
module psd_prescaler
    import psd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mod_boot,
    input  logic mod_next,
    output logic ps_first,
    output logic ps_end,
    output logic mod_now
);
    logic [3:0] cnt_q;
    logic       mod_q;
    logic       run_q;

    // Flag the first and the last clock of the current prescaler cycle.
    always_comb begin
        ps_first = (cnt_q == 4'd0);
        ps_end   = (cnt_q == (mod_q ? 4'(PRE_LONG - 1) : 4'(PRE_SHORT - 1)));
    end

    // Count input clocks and re-time the modulus request at the cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mod_q <= mod_boot;
        end else if (ps_end) begin
            cnt_q <= '0;
            mod_q <= mod_next;
        end else begin
            cnt_q <= cnt_q + 4'd1;
        end
    end

    // Note that at least one clock has run outside reset, so past values are meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    assign mod_now = mod_q;

    AST_PRE_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= 4'(PRE_LONG - 1)); // R2
    AST_MOD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !$past(ps_end)) |-> $stable(mod_q)); // R2
endmodule

// File: rtl/psd_swallow_ctrl.sv
// Module psd_swallow_ctrl
// Programmable counter for the pulse-swallow scheme. It counts M prescaler
// cycles per period, of which the first A are requested at divide-by-11.
// It keeps an active divisor and a shadow divisor; the shadow is moved over
// only at the end of a period. It also drives the early and the exact pulse.
// Assumes commit carries a divisor with M >= A and M >= 2.
module psd_swallow_ctrl
    import psd_pkg::*;
#(
    parameter int N_BOOT = 50000,
    parameter int M_W    = 15
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ps_first,
    input  logic           ps_end,
    input  logic           commit,
    input  logic [M_W-1:0] commit_m,
    input  bcd_t           commit_a,
    output logic           mod_boot,
    output logic           mod_next,
    output logic           fast_pulse,
    output logic           slow_pulse
);
    localparam logic [M_W-1:0] BOOT_M = M_W'(N_BOOT / 10);
    localparam bcd_t           BOOT_A = 4'(N_BOOT % 10);

    logic [M_W-1:0] act_m_q, shd_m_q, m_left_q;
    bcd_t           act_a_q, shd_a_q, sw_rem_q;
    logic           pend_q;
    logic           fast_q, slow_q;

    logic           last_cyc;
    logic           per_end;
    logic [M_W-1:0] nxt_m;
    bcd_t           nxt_a;

    // Find the final prescaler cycle and select the divisor for the next period.
    always_comb begin
        last_cyc = (m_left_q == M_W'(1));
        per_end  = ps_end && last_cyc;
        nxt_m    = pend_q ? shd_m_q : act_m_q;
        nxt_a    = pend_q ? shd_a_q : act_a_q;
        mod_next = per_end ? (nxt_a != 4'd0) : (sw_rem_q > 4'd1);
        mod_boot = (BOOT_A != 4'd0);
    end

    // Step the cycle counters, swap in the shadow divisor at period end, and register the pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_m_q  <= BOOT_M;
            act_a_q  <= BOOT_A;
            shd_m_q  <= BOOT_M;
            shd_a_q  <= BOOT_A;
            pend_q   <= 1'b0;
            m_left_q <= BOOT_M;
            sw_rem_q <= BOOT_A;
            fast_q   <= 1'b0;
            slow_q   <= 1'b0;
        end else begin
            fast_q <= ps_first && last_cyc;
            slow_q <= per_end;
            if (per_end) begin
                act_m_q  <= nxt_m;
                act_a_q  <= nxt_a;
                m_left_q <= nxt_m;
                sw_rem_q <= nxt_a;
                pend_q   <= commit;
            end else begin
                if (ps_end) begin
                    m_left_q <= m_left_q - M_W'(1);
                    if (sw_rem_q != 4'd0) sw_rem_q <= sw_rem_q - 4'd1;
                end
                if (commit) pend_q <= 1'b1;
            end
            if (commit) begin
                shd_m_q <= commit_m;
                shd_a_q <= commit_a;
            end
        end
    end

    assign fast_pulse = fast_q;
    assign slow_pulse = slow_q;

    AST_SLOW_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        slow_q |=> !slow_q); // R3
    AST_FAST_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        fast_q |=> !fast_q); // R3
    AST_FAST_LEADS_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        slow_q |-> ($past(fast_q, 9) || $past(fast_q, 10))); // R3
    AST_SWALLOW_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sw_rem_q) <= int'(m_left_q)); // R2
    AST_COMMIT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> pend_q); // R4
endmodule

// File: rtl/psd_divider.sv
// Module psd_divider
// Top level of the pulse-swallow BCD divider. It joins the digit loader,
// the programmable swallow counter and the dual-modulus prescaler.
// Assumes N_MIN >= 90, so that every legal divisor has M >= A.
module psd_divider
    import psd_pkg::*;
#(
    parameter int NUM_DIGITS = 6,
    parameter int N_MIN      = 50000,
    parameter int N_MAX      = 220000,
    parameter int N_BOOT     = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dig_valid,
    input  logic [3:0] dig_data,
    input  logic       dig_last,
    output logic       fast_pulse,
    output logic       slow_pulse,
    output logic       mod_hi,
    output logic       load_err
);
    localparam int M_W = $clog2(N_MAX / 10 + 1);

    logic           commit;
    logic [M_W-1:0] commit_m;
    bcd_t           commit_a;
    logic           ps_first, ps_end;
    logic           mod_boot, mod_next;

    psd_loader #(
        .NUM_DIGITS(NUM_DIGITS), .N_MIN(N_MIN), .N_MAX(N_MAX), .M_W(M_W)
    ) u_loader (
        .clk(clk), .rst_n(rst_n),
        .dig_valid(dig_valid), .dig_data(dig_data), .dig_last(dig_last),
        .commit(commit), .commit_m(commit_m), .commit_a(commit_a),
        .load_err(load_err)
    );

    psd_swallow_ctrl #(
        .N_BOOT(N_BOOT), .M_W(M_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ps_first(ps_first), .ps_end(ps_end),
        .commit(commit), .commit_m(commit_m), .commit_a(commit_a),
        .mod_boot(mod_boot), .mod_next(mod_next),
        .fast_pulse(fast_pulse), .slow_pulse(slow_pulse)
    );

    psd_prescaler u_pre (
        .clk(clk), .rst_n(rst_n),
        .mod_boot(mod_boot), .mod_next(mod_next),
        .ps_first(ps_first), .ps_end(ps_end), .mod_now(mod_hi)
    );
endmodule

// File: tb/psd_divider_tb.sv
// Bench for psd_divider. A negedge monitor holds a model of the divisor
// in force and judges every period, swallow count and pulse shape.
// Directed and seeded random loads drive the design.
module psd_divider_tb;
    localparam int NDIG  = 3;
    localparam int NMIN  = 150;
    localparam int NMAX  = 620;
    localparam int NBOOT = 150;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dig_valid = 1'b0;
    logic [3:0] dig_data = 4'd0;
    logic       dig_last = 1'b0;
    logic       fast_pulse, slow_pulse, mod_hi, load_err;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int cur_n = NBOOT, pend_n = 0, pend_c = 0, last_e = 0, last_f = -100, last_int = 0, hi_cnt = 0;
    bit pend_v = 0, have_last = 0, prev_slow = 0, prev_fast = 0, done = 0;
    int seed_sink;

    psd_divider #(.NUM_DIGITS(NDIG), .N_MIN(NMIN), .N_MAX(NMAX), .N_BOOT(NBOOT)) u_dut (
        .clk(clk), .rst_n(rst_n), .dig_valid(dig_valid), .dig_data(dig_data),
        .dig_last(dig_last), .fast_pulse(fast_pulse), .slow_pulse(slow_pulse),
        .mod_hi(mod_hi), .load_err(load_err));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    function automatic bit legal(input int n);
        return (n >= NMIN) && (n <= NMAX) && (n / 10 >= n % 10);
    endfunction

    // Period model: judge each slow pulse, then adopt a pending divisor by the edge rule.
    always @(negedge clk) begin
        if (rst_n) begin
            if (slow_pulse) begin
                if (prev_slow) chk(0, "R3 slow width", 2, 1);
                if (have_last) begin
                    chk(cyc - last_e == cur_n, "R1 slow period", cyc - last_e, cur_n);
                    chk(hi_cnt == 11 * (cur_n % 10), "R2 divide-by-11 clocks", hi_cnt, 11 * (cur_n % 10));
                    chk(cyc - last_f == 9, "R3 fast lead", cyc - last_f, 9);
                    last_int = cyc - last_e;
                end
                if (pend_v && cyc >= pend_c + 3) begin
                    cur_n  = pend_n;
                    pend_v = 0;
                end
                last_e = cyc; have_last = 1; hi_cnt = 0;
            end
            if (fast_pulse) begin
                if (prev_fast) chk(0, "R3 fast width", 2, 1);
                last_f = cyc;
            end
            hi_cnt += int'(mod_hi);
            prev_slow = slow_pulse;
            prev_fast = fast_pulse;
        end
    end

    task automatic align();
        @(posedge clk); #2;
    endtask

    task automatic put(input logic [3:0] d, input bit last);
        dig_valid = 1'b1; dig_data = d; dig_last = last;
        @(posedge clk); #2;
        dig_valid = 1'b0; dig_last = 1'b0;
    endtask

    // Check load_err one clock after the units digit; R5 for refusals, R6 for acceptance.
    task automatic check_err(input bit exp_err);
        @(negedge clk);
        if (exp_err) chk(load_err == 1'b1, "R5 refused load flag", int'(load_err), 1);
        else         chk(load_err == 1'b0, "R6 accepted load clears flag", int'(load_err), 0);
    endtask

    task automatic send_n(input int n);
        bit ok;
        ok = legal(n);
        put(4'(n / 100), 0);
        put(4'((n / 10) % 10), 0);
        if (ok) begin pend_n = n; pend_c = cyc; pend_v = 1; end
        put(4'(n % 10), 1);
        check_err(!ok);
    endtask

    task automatic wait_slow(input int k);
        for (int i = 0; i < k; i++) begin
            do begin @(negedge clk); #1; end while (!slow_pulse);
        end
    endtask

    task automatic do_reset();
        align();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!fast_pulse && !slow_pulse && !load_err, "R7 outputs low in reset",
            int'({fast_pulse, slow_pulse, load_err}), 0);
        align();
        rst_n = 1'b1;
        cur_n = NBOOT; pend_v = 0; last_e = cyc; have_last = 1; hi_cnt = 0;
        prev_slow = 0; prev_fast = 0;
    endtask

    // Put the units digit at offset off clocks before the next period end (2 = same-edge collision).
    task automatic load_near_end(input int n, input int off);
        int s, old_n, target;
        wait_slow(2);
        wait_slow(1);
        s = cyc; old_n = cur_n;
        target = s + old_n - off - 2;
        do begin @(posedge clk); #2; end while (cyc != target);
        send_n(n);
        wait_slow(2);
        if (off == 2) chk(last_int == old_n, "R4 collision keeps old divisor", last_int, old_n);
        else          chk(last_int == n, "R4 early load applies next period", last_int, n);
        wait_slow(1);
        chk(last_int == n, "R4 new divisor in force", last_int, n);
    endtask

    initial begin
        seed_sink = $urandom(32'd7411);
        do_reset();
        wait_slow(3);
        // Directed legal divisors: range ends, largest units digit, a middle value.
        send_n(620); wait_slow(3);
        send_n(150); wait_slow(3);
        send_n(159); wait_slow(3);
        send_n(385); wait_slow(3);
        // Refusals: below and above range, bad digits, too many digits.
        send_n(149); wait_slow(2);
        send_n(621); wait_slow(2);
        align(); put(4'd3, 0); put(4'd10, 0); put(4'd5, 1); check_err(1); wait_slow(2);
        align(); put(4'd2, 0); put(4'd5, 0); put(4'd12, 1); check_err(1); wait_slow(2);
        align(); put(4'd1, 0); put(4'd2, 0); put(4'd3, 0); put(4'd4, 1); check_err(1); wait_slow(2);
        chk(cur_n == 385, "R5 divisor kept after refusals", cur_n, 385);
        align(); send_n(472); wait_slow(3);
        // Commit that lands on a period end, then one clock earlier.
        load_near_end(233, 2);
        load_near_end(517, 3);
        // A pending divisor and a set error flag are cleared by reset.
        align(); send_n(400); align(); send_n(700);
        do_reset();
        wait_slow(2);
        chk(last_int == NBOOT, "R7 boot divisor after reset", last_int, NBOOT);
        // Seeded random loads at random offsets.
        for (int i = 0; i < 24; i++) begin
            int n, gap;
            n = $urandom_range(660, 120);
            gap = $urandom_range(300, 0);
            repeat (gap) @(posedge clk);
            align();
            send_n(n);
            wait_slow(3);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete, actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule